// File: doc/BRIEF.md
# Bit-Signal Cross-Correlation Accumulator

This block holds a matrix of running correlations between a vector of antipodal bits and a vector of signed 8-bit received samples. The matrix has ROWS rows, one per bit position, and COLS columns, one per sample position. The correlation is kept over a sliding window. Each update strobe delivers two pairs. The first pair is the bit vector and sample vector entering the window. The second pair is the bit vector and sample vector leaving the window. Every entry takes the product of the entering pair and gives back the product of the leaving pair.

No multiplier is used. A bit selects whether its sample is added or subtracted. Both the entering and the leaving contribution are folded into one signed delta, and that delta is applied to the entry in a single write with saturation. The sweep is column-serial: one adder lane per row, and one column per clock. An update therefore completes in COLS cycles, and a one-cycle done pulse marks the end of it. Any entry can be read at any time through a combinational row/column read port.

Top module: `ccorr_accum`

## Requirements
- R1: After reset every entry reads 0, and both busy and done are low.
- R2: A bit value of 1 stands for +1 and a bit value of 0 stands for −1. Samples are 8-bit two's complement, sign-extended before accumulation. Bit r of a bit vector pairs with row r. Sample c occupies bits [8c+7:8c] of a sample vector.
- R3: One accepted update changes entry (r,c) by (+s or −s of the newest sample c, signed by newest bit r) minus (+s or −s of the oldest sample c, signed by oldest bit r).
- R4: Entries are 16-bit signed and saturate at −32768 and 32767. The clamp is applied once, to the combined sum of both contributions, so a contribution that cancels out leaves a saturated entry unchanged.
- R5: A strobe is accepted only while busy is low. Busy is high from the cycle after acceptance for exactly COLS cycles.
- R6: Done is a single-cycle pulse in the first cycle after the last column has been written, which is COLS cycles after the accepting edge. Busy is low in that cycle.
- R7: A strobe raised while busy is high is ignored. Input changes during an update do not affect it, because the inputs are captured at acceptance.
- R8: The rd_data output shows entry (rd_row, rd_col) combinationally.
- R9: Columns are written in ascending order, one per clock. Column c is written at the (c+1)-th edge after acceptance, and columns not yet reached keep their old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_i | input | 1 | Update strobe |
| new_bits | input | ROWS | Entering bit vector (1 = +1) |
| new_samp | input | COLS*8 | Entering sample vector |
| old_bits | input | ROWS | Leaving bit vector (1 = +1) |
| old_samp | input | COLS*8 | Leaving sample vector |
| rd_row | input | clog2(ROWS) | Read row index |
| rd_col | input | clog2(COLS) | Read column index |
| rd_data | output | 16 | Selected entry, signed |
| busy | output | 1 | Column sweep in progress |
| done | output | 1 | One-cycle end-of-update pulse |

## Verification
The entering and leaving contributions meet on the same entry in the same write. The bench drives both with nonzero samples and with every combination of bit signs across the rows, then compares each entry against an arithmetic model. The sharpest case of this collision is a saturated entry receiving equal and opposite contributions. A single clamp leaves the entry at 32767, whereas clamping each contribution separately would lower it to 32640. A second collision is a strobe arriving while a sweep is still running; the bench judges it by reading back the whole matrix after done.

// File: rtl/ccorr_pkg.sv
package ccorr_pkg;

  // Signed term for one antipodal bit times one sample: bit 1 is +1, bit 0 is -1.
  function automatic int bit_term(input logic b, input int s);
    return b ? s : -s;
  endfunction

  // Net change of one entry: entering product minus leaving product.
  function automatic int net_delta(input logic b_in, input int s_in,
                                   input logic b_out, input int s_out);
    return bit_term(b_in, s_in) - bit_term(b_out, s_out);
  endfunction

  // Clamp a value to the signed range of a w-bit word.
  function automatic int sat_to(input int v, input int w);
    int hi;
    int lo;
    hi = (1 << (w - 1)) - 1;
    lo = -(1 << (w - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

endpackage

// File: rtl/ccorr_seq.sv
module ccorr_seq #(
  parameter int COLS = 32,
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_i,
  output logic          accept,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] col
);

  localparam logic [CW-1:0] LAST = CW'(COLS - 1);

  logic at_last;

  assign accept  = upd_i & ~busy;
  assign at_last = busy & (col == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      col  <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy <= 1'b1;
        col  <= '0;
      end else if (at_last) begin
        busy <= 1'b0;
        done <= 1'b1;
        col  <= '0;
      end else if (busy) begin
        col <= col + 1'b1;
      end
    end
  end

  // R5: an accepted strobe starts the sweep on the next cycle
  p_accept_starts_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && col == '0));

  // R6: done only at the end of a sweep, and only for one cycle
  p_done_after_sweep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R9: columns advance by one per cycle
  p_col_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && col != LAST) |=> (busy && col == CW'($past(col) + 1'b1)));

endmodule

// File: rtl/ccorr_lane.sv
module ccorr_lane
  import ccorr_pkg::*;
#(
  parameter int SW = 8,
  parameter int AW = 16
) (
  input  logic          b_new,
  input  logic          b_old,
  input  logic [SW-1:0] s_new,
  input  logic [SW-1:0] s_old,
  input  logic [AW-1:0] acc,
  output logic [AW-1:0] nxt,
  output logic          moved
);

  int delta;
  int sum_raw;
  int sum_sat;

  always_comb begin
    delta   = net_delta(b_new, int'($signed(s_new)), b_old, int'($signed(s_old)));
    sum_raw = int'($signed(acc)) + delta;
    sum_sat = sat_to(sum_raw, AW);
    nxt     = AW'(sum_sat);
    moved   = (delta != 0);
  end

  // R4: the saturated result never moves against the sign of the net delta
  always_comb begin
    if (delta > 0) begin
      p_sat_up_r4: assert ($signed(nxt) >= $signed(acc));
    end else if (delta < 0) begin
      p_sat_down_r4: assert ($signed(nxt) <= $signed(acc));
    end else begin
      p_zero_hold_r4: assert (nxt == acc);
    end
  end

endmodule

// File: rtl/ccorr_store.sv
module ccorr_store #(
  parameter int ROWS = 8,
  parameter int COLS = 32,
  parameter int AW   = 16,
  localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW  = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [CW-1:0]      wr_col,
  input  logic [ROWS*AW-1:0] wr_data,
  output logic [ROWS*AW-1:0] col_data,
  input  logic [RW-1:0]      rd_row,
  input  logic [CW-1:0]      rd_col,
  output logic [AW-1:0]      rd_data
);

  logic [AW-1:0] mem [ROWS][COLS];
  logic [ROWS*COLS*AW-1:0] mem_flat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++)
          mem[r][c] <= '0;
    end else if (wr_en) begin
      for (int r = 0; r < ROWS; r++)
        mem[r][wr_col] <= wr_data[r*AW +: AW];
    end
  end

  genvar gr, gc;
  generate
    for (gr = 0; gr < ROWS; gr++) begin : g_row
      assign col_data[gr*AW +: AW] = mem[gr][wr_col];
      for (gc = 0; gc < COLS; gc++) begin : g_col
        assign mem_flat[(gr*COLS+gc)*AW +: AW] = mem[gr][gc];
      end
    end
  endgenerate

  always_comb begin
    if (int'(rd_row) < ROWS && int'(rd_col) < COLS)
      rd_data = mem[rd_row][rd_col];
    else
      rd_data = '0;
  end

  // R7: with no sweep running, no entry changes
  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mem_flat));

endmodule

// File: rtl/ccorr_accum.sv
module ccorr_accum
  import ccorr_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 32,
  parameter int SW   = 8,
  parameter int AW   = 16,
  localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW  = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               upd_i,
  input  logic [ROWS-1:0]    new_bits,
  input  logic [COLS*SW-1:0] new_samp,
  input  logic [ROWS-1:0]    old_bits,
  input  logic [COLS*SW-1:0] old_samp,
  input  logic [RW-1:0]      rd_row,
  input  logic [CW-1:0]      rd_col,
  output logic [AW-1:0]      rd_data,
  output logic               busy,
  output logic               done
);

  logic               accept;
  logic [CW-1:0]      col;
  logic [ROWS-1:0]    nb_q, ob_q;
  logic [COLS*SW-1:0] ns_q, os_q;
  logic [SW-1:0]      ns_col, os_col;
  logic [ROWS*AW-1:0] col_cur, col_nxt;
  logic [ROWS-1:0]    lane_moved;

  ccorr_seq #(.COLS(COLS)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd_i  (upd_i),
    .accept (accept),
    .busy   (busy),
    .done   (done),
    .col    (col)
  );

  // Capture both pairs at acceptance; later input changes do not matter.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nb_q <= '0;
      ob_q <= '0;
      ns_q <= '0;
      os_q <= '0;
    end else if (accept) begin
      nb_q <= new_bits;
      ob_q <= old_bits;
      ns_q <= new_samp;
      os_q <= old_samp;
    end
  end

  assign ns_col = ns_q[int'(col)*SW +: SW];
  assign os_col = os_q[int'(col)*SW +: SW];

  genvar gr;
  generate
    for (gr = 0; gr < ROWS; gr++) begin : g_lane
      ccorr_lane #(.SW(SW), .AW(AW)) u_lane (
        .b_new (nb_q[gr]),
        .b_old (ob_q[gr]),
        .s_new (ns_col),
        .s_old (os_col),
        .acc   (col_cur[gr*AW +: AW]),
        .nxt   (col_nxt[gr*AW +: AW]),
        .moved (lane_moved[gr])
      );
    end
  endgenerate

  ccorr_store #(.ROWS(ROWS), .COLS(COLS), .AW(AW)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (busy),
    .wr_col   (col),
    .wr_data  (col_nxt),
    .col_data (col_cur),
    .rd_row   (rd_row),
    .rd_col   (rd_col),
    .rd_data  (rd_data)
  );

  // R7: captured operands stay fixed for the whole sweep
  p_ignore_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable({nb_q, ob_q, ns_q, os_q}));

  // R3: a lane whose net delta is zero leaves its entry untouched
  p_still_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !lane_moved[0]) |=> (u_store.mem[0][$past(col)] == $past(col_cur[AW-1:0])));

endmodule

// File: tb/ccorr_accum_test.sv
module ccorr_accum_test;

  localparam int ROWS = 4;
  localparam int COLS = 4;
  localparam int SW   = 8;
  localparam int AW   = 16;
  localparam int RW   = 2;
  localparam int CW   = 2;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               upd_i = 1'b0;
  logic [ROWS-1:0]    new_bits = '0, old_bits = '0;
  logic [COLS*SW-1:0] new_samp = '0, old_samp = '0;
  logic [RW-1:0]      rd_row = '0;
  logic [CW-1:0]      rd_col = '0;
  logic [AW-1:0]      rd_data;
  logic               busy, done;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  int mdl [ROWS][COLS];
  int seed = 12345;

  always #5 clk = ~clk;

  ccorr_accum #(.ROWS(ROWS), .COLS(COLS), .SW(SW), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .upd_i(upd_i),
    .new_bits(new_bits), .new_samp(new_samp),
    .old_bits(old_bits), .old_samp(old_samp),
    .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data),
    .busy(busy), .done(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int next_rand();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 8) & 32'h7fff_ffff;
  endfunction

  function automatic int lim(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int samp_of(input logic [COLS*SW-1:0] v, input int c);
    logic signed [7:0] t;
    t = v[c*8 +: 8];
    return int'(t);
  endfunction

  task automatic read_at(input int r, input int c, output int v);
    rd_row = RW'(r);
    rd_col = CW'(c);
    #1;
    v = int'($signed(rd_data));
  endtask

  task automatic model_apply(input logic [ROWS-1:0] nb, input logic [COLS*SW-1:0] ns,
                             input logic [ROWS-1:0] ob, input logic [COLS*SW-1:0] os);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        int add_part, sub_part;
        add_part = nb[r] ? samp_of(ns, c) : -samp_of(ns, c);
        sub_part = ob[r] ? samp_of(os, c) : -samp_of(os, c);
        mdl[r][c] = lim(mdl[r][c] + add_part - sub_part);
      end
  endtask

  task automatic verify_all(input string req);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        int v;
        read_at(r, c, v);
        chk(req, v, mdl[r][c]);
      end
  endtask

  // Drive one update and wait for done; optional strobe while busy (R7).
  task automatic run_update(input logic [ROWS-1:0] nb, input logic [COLS*SW-1:0] ns,
                            input logic [ROWS-1:0] ob, input logic [COLS*SW-1:0] os,
                            input bit poke_busy, input bit check_all);
    int cnt;
    @(negedge clk);
    new_bits = nb; new_samp = ns; old_bits = ob; old_samp = os;
    upd_i = 1'b1;
    @(negedge clk);
    chk("R5 busy after accept", int'(busy), 1);
    if (poke_busy) begin
      new_bits = ~nb; new_samp = ~ns; old_bits = ~ob; old_samp = ns;
      upd_i = 1'b1;
    end else begin
      upd_i = 1'b0;
    end
    cnt = 0;
    while (!done && cnt < 40) begin
      @(negedge clk);
      cnt++;
      if (cnt == COLS - 1) upd_i = 1'b0;
    end
    upd_i = 1'b0;
    chk("R6 done latency", cnt, COLS);
    chk("R6 busy low with done", int'(busy), 0);
    model_apply(nb, ns, ob, os);
    if (check_all) verify_all(poke_busy ? "R7 strobe while busy" : "R3 entry update");
    @(negedge clk);
    chk("R6 done single pulse", int'(done), 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        mdl[r][c] = 0;
  endtask

  function automatic logic [COLS*SW-1:0] fill(input int s);
    logic [COLS*SW-1:0] v;
    for (int c = 0; c < COLS; c++) v[c*8 +: 8] = 8'(s);
    return v;
  endfunction

  initial begin
    logic [COLS*SW-1:0] ns, os;
    int v, before0, before1;

    do_reset();
    // R1: reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    verify_all("R1 reset zero");

    // R2/R3: sweep every new/old bit combination against corner samples
    for (int p = 0; p < 16; p++) begin
      ns[7:0] = 8'sd127; ns[15:8] = -8'sd128; ns[23:16] = 8'(p * 9 - 60); ns[31:24] = 8'(-p);
      os[7:0] = 8'(p * 7); os[15:8] = 8'sd127; os[23:16] = -8'sd128; os[31:24] = 8'(3 - p);
      run_update(4'(p), ns, 4'(~(p ^ (p >> 1))), os, 1'b0, 1'b1);
    end
    // R2 single-entry sign check: bit 1 adds, bit 0 subtracts
    do_reset();
    run_update(4'b0101, fill(10), 4'b0011, fill(3), 1'b0, 1'b0);
    read_at(0, 0, v); chk("R2 +10 -(+3)", v, 7);
    read_at(1, 0, v); chk("R2 -10 -(+3)", v, -13);
    read_at(2, 1, v); chk("R2 +10 -(-3)", v, 13);
    read_at(3, 2, v); chk("R2 -10 -(-3)", v, -7);
    read_at(3, 3, v); chk("R8 read port", v, -7);

    // Random mixes (R3)
    for (int k = 0; k < 24; k++) begin
      ns = {next_rand(), next_rand()}[COLS*SW-1:0];
      os = {next_rand(), next_rand()}[COLS*SW-1:0];
      run_update(4'(next_rand()), ns, 4'(next_rand()), os, 1'b0, 1'b1);
    end

    // R7: strobe held and data changed while busy
    run_update(4'b1100, fill(-50), 4'b1010, fill(20), 1'b1, 1'b1);

    // R9: column order mid-sweep
    @(negedge clk);
    read_at(0, 0, before0);
    read_at(0, 1, before1);
    @(negedge clk);
    new_bits = 4'b1111; old_bits = 4'b0000; new_samp = fill(5); old_samp = fill(0);
    upd_i = 1'b1;
    @(negedge clk);
    upd_i = 1'b0;
    @(negedge clk);
    read_at(0, 0, v); chk("R9 col0 written first", v, lim(before0 + 5));
    read_at(0, 1, v); chk("R9 col1 not yet", v, before1);
    while (!done) @(negedge clk);
    model_apply(4'b1111, fill(5), 4'b0000, fill(0));
    verify_all("R9 sweep complete");

    // R4: positive saturation then combined cancel
    do_reset();
    for (int k = 0; k < 260; k++)
      run_update(4'b1111, fill(127), 4'b0000, fill(0), 1'b0, 1'b0);
    verify_all("R4 positive clamp");
    run_update(4'b1111, fill(127), 4'b1111, fill(127), 1'b0, 1'b0);
    read_at(1, 2, v); chk("R4 single clamp on combined sum", v, 32767);
    run_update(4'b1111, fill(0), 4'b1111, fill(127), 1'b0, 1'b0);
    read_at(2, 3, v); chk("R4 leave saturation", v, 32640);
    verify_all("R4 model after clamp");

    // R4: negative saturation
    do_reset();
    for (int k = 0; k < 260; k++)
      run_update(4'b0000, fill(127), 4'b1111, fill(0), 1'b0, 1'b0);
    verify_all("R4 negative clamp");
    read_at(0, 0, v); chk("R4 floor value", v, -32768);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1500000;
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule